// File: doc/BRIEF.md
# Dual-Mode Processor Bus Port for a Time-Slot Switch

This block is the host-side slave port of a time-slot switch. A processor reaches four control registers, the connection memory and the data memory through it. The port runs in one of two bus modes, picked by a static strap input. In the shared-bus mode, an address strobe captures the address from the low data byte. In the separate-bus mode, a dedicated 8-bit address input selects the location. Chip select, data strobe and a read/write line drive each transfer. The port answers with an active-low transfer acknowledge.

The top address bit divides the space. When it is clear, the low bits pick a register. When it is set, the low seven bits pick a channel inside a 128-entry window. Two fields of the control register place that window: a stream field selects which stream's block is reached, and a memory-select bit chooses connection memory or data memory. The processor can only read the data memory and the frame-alignment word. The switch datapath fills the data memory through a separate write port, and it supplies the frame-alignment value as an input.

Top module: `tsw_host_port`

## Requirements
- R1: In shared-bus mode (`bus_shared`=1), the address is taken from `d_lo_in` on each clock edge where `addr_stb` is high. It is then held until the next such edge, so the later contents of `d_lo_in` (the write data) do not change it.
- R2: In separate-bus mode (`bus_shared`=0), the address comes from `addr_in`, and `d_lo_in` carries only data.
- R3: With address bit 7 clear, offset 0x00 is the control register, 0x01 the interface-mode register and 0x03 the frame-offset register. Each holds 16 bits and reads back what was written.
- R4: Offset 0x02 returns `frame_pos_in`. A write to it is acknowledged and has no effect.
- R5: Any other offset with bit 7 clear reads as zero. A write to it changes no register.
- R6: With address bit 7 set and control bit 7 (memory select) clear, the access reaches the 16-bit connection-memory word at channel = address bits 6..0 of the stream given by control bits 1..0.
- R7: With address bit 7 set and control bit 7 set, a read returns the 8-bit data-memory byte of that stream and channel, zero-extended. A processor write is acknowledged and leaves the byte unchanged.
- R8: Different stream-field values reach separate storage, so the same channel offset under two streams holds independent values.
- R9: `dta_n` falls one clock after an edge that sees `cs_n` and `ds_n` both low. It stays low while both remain low. It rises one clock after either goes high. Each strobe performs exactly one access.
- R10: After reset, `dta_n` is high, `d_oe` is low and every writable register reads zero.
- R11: `d_oe` is high only while a read is being acknowledged (`dta_n` low, `rd_wr_n`=1 meaning read, `cs_n` low). Read data appears on `d_hi_out`/`d_lo_out` when `dta_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_shared | input | 1 | 1 = shared address/data mode, 0 = separate address bus |
| addr_stb | input | 1 | Address strobe for shared mode, active high |
| addr_in | input | 8 | Address for separate-bus mode |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| d_lo_in | input | 8 | Low data byte in (address in shared mode) |
| d_hi_in | input | 8 | High data byte in |
| d_lo_out | output | 8 | Low read-data byte |
| d_hi_out | output | 8 | High read-data byte |
| d_oe | output | 1 | Read-data drive enable |
| dta_n | output | 1 | Transfer acknowledge, active low |
| frame_pos_in | input | 16 | Value reported by the read-only frame-alignment word |
| sw_dm_we | input | 1 | Switch-side data-memory write enable |
| sw_dm_idx | input | 9 | Switch-side data-memory index {stream, channel} |
| sw_dm_data | input | 8 | Switch-side data-memory write byte |

## Verification
The assertions check the handshake on every cycle: the acknowledge falls only after a sampled strobe, it is released after the strobe is removed, and it is high after reset. They also check that the drive enable never rises without a read acknowledge, and that the captured shared-mode address holds between address strobes. The address decode, the stream and memory-select routing, and the read-only behaviour of the frame word and the data memory can only be shown by the bench's scenarios. Those scenarios write a location and read it back, or check that a write left the old value in place.

// File: rtl/tsw_host_port_pkg.sv
// Package: shared constants and types of the host port.
// Assumes a fixed 8-bit address: bit 7 splits register space from memory space.
package tsw_host_port_pkg;
    localparam int ADDR_W   = 8;
    localparam int HDATA_W  = 16;
    localparam int MSEL_BIT = 7;

    localparam logic [6:0] OFS_CTRL  = 7'h00;
    localparam logic [6:0] OFS_IMODE = 7'h01;
    localparam logic [6:0] OFS_FPOS  = 7'h02;
    localparam logic [6:0] OFS_FOFS  = 7'h03;

    typedef enum logic [1:0] {
        RGN_REG  = 2'd0,
        RGN_CONN = 2'd1,
        RGN_DATA = 2'd2
    } region_e;
endpackage

// File: rtl/tsw_addr_capture.sv
// Module: picks the access address for either bus mode.
// Assumes the strobe and bus inputs are synchronous to clk.
module tsw_addr_capture
    import tsw_host_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_shared,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] shared_bus,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] held_q;

    // Latch the shared-bus address while the address strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (addr_stb)
            held_q <= shared_bus;
    end

    // Select the address source for the active bus mode.
    always_comb begin
        addr_out = bus_shared ? held_q : addr_in;
    end
endmodule

// File: rtl/tsw_strobe_ctl.sv
// Module: turns chip select and data strobe into one access pulse and an acknowledge.
// Assumes one access per strobe; the acknowledge holds until the strobe is removed.
module tsw_strobe_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ds_n,
    output logic access,
    output logic ack
);
    logic ack_q;
    logic strobe_on;

    // Strobe is active only with both chip select and data strobe low.
    always_comb begin
        strobe_on = !cs_n && !ds_n;
        access    = strobe_on && !ack_q;
        ack       = ack_q;
    end

    // Raise the acknowledge after the access edge and drop it on strobe removal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else if (!strobe_on)
            ack_q <= 1'b0;
        else if (access)
            ack_q <= 1'b1;
    end
endmodule

// File: rtl/tsw_reg_file.sv
// Module: the four control registers at offsets 0..3 of register space.
// Assumes the frame word is supplied from outside and cannot be written.
module tsw_reg_file
    import tsw_host_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [6:0]         ofs,
    input  logic [HDATA_W-1:0] wr_data,
    input  logic [HDATA_W-1:0] frame_pos,
    output logic [HDATA_W-1:0] rd_data,
    output logic [HDATA_W-1:0] ctrl
);
    logic [HDATA_W-1:0] ctrl_q, imode_q, fofs_q;

    // Update the writable registers; other offsets ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            imode_q <= '0;
            fofs_q  <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_CTRL:  ctrl_q  <= wr_data;
                OFS_IMODE: imode_q <= wr_data;
                OFS_FOFS:  fofs_q  <= wr_data;
                default:   ;
            endcase
        end
    end

    // Read-back mux; undefined offsets read zero.
    always_comb begin
        case (ofs)
            OFS_CTRL:  rd_data = ctrl_q;
            OFS_IMODE: rd_data = imode_q;
            OFS_FPOS:  rd_data = frame_pos;
            OFS_FOFS:  rd_data = fofs_q;
            default:   rd_data = '0;
        endcase
        ctrl = ctrl_q;
    end
endmodule

// File: rtl/tsw_mem_bank.sv
// Module: simple single-write, single-read array modelling a switch memory.
// Assumes DEPTH is a power of two; the read port is asynchronous.
module tsw_mem_bank #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [WIDTH-1:0] w_data,
    input  logic [IDX_W-1:0] r_idx,
    output logic [WIDTH-1:0] r_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Clear contents at start so unwritten words read as zero.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    // Store one word per enabled edge.
    always_ff @(posedge clk) begin
        if (we)
            mem[w_idx] <= w_data;
    end

    // Asynchronous read of the addressed word.
    always_comb begin
        r_data = mem[r_idx];
    end
endmodule

// File: rtl/tsw_host_port.sv
// Module: top of the host port: decodes register space and the
// stream-windowed connection and data memories, and blocks processor writes
// to read-only locations. Assumes bus inputs synchronous to clk.
module tsw_host_port
    import tsw_host_port_pkg::*;
#(
    parameter int STREAMS = 4,
    parameter int CHANS   = 128,
    parameter int DM_W    = 8,
    localparam int STRM_W = $clog2(STREAMS),
    localparam int CHAN_W = $clog2(CHANS),
    localparam int IDX_W  = STRM_W + CHAN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_shared,
    input  logic               addr_stb,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               cs_n,
    input  logic               ds_n,
    input  logic               rd_wr_n,
    input  logic [7:0]         d_lo_in,
    input  logic [7:0]         d_hi_in,
    output logic [7:0]         d_lo_out,
    output logic [7:0]         d_hi_out,
    output logic               d_oe,
    output logic               dta_n,
    input  logic [HDATA_W-1:0] frame_pos_in,
    input  logic               sw_dm_we,
    input  logic [IDX_W-1:0]   sw_dm_idx,
    input  logic [DM_W-1:0]    sw_dm_data
);
    logic [ADDR_W-1:0]  acc_addr;
    logic               access, ack;
    logic [HDATA_W-1:0] wr_word, reg_rd, ctrl, cm_rd, rd_mux, rdata_q;
    logic [DM_W-1:0]    dm_rd;
    logic [IDX_W-1:0]   mem_idx;
    region_e            region;
    logic               reg_we, cm_we;

    tsw_addr_capture u_addr (
        .clk(clk), .rst_n(rst_n), .bus_shared(bus_shared), .addr_stb(addr_stb),
        .shared_bus(d_lo_in), .addr_in(addr_in), .addr_out(acc_addr)
    );

    tsw_strobe_ctl u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n),
        .access(access), .ack(ack)
    );

    // Decode region, memory index and write enables for the current access.
    always_comb begin
        wr_word = {d_hi_in, d_lo_in};
        mem_idx = {ctrl[STRM_W-1:0], acc_addr[CHAN_W-1:0]};
        if (!acc_addr[ADDR_W-1])
            region = RGN_REG;
        else if (ctrl[MSEL_BIT])
            region = RGN_DATA;
        else
            region = RGN_CONN;
        reg_we = access && !rd_wr_n && (region == RGN_REG);
        cm_we  = access && !rd_wr_n && (region == RGN_CONN);
    end

    tsw_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .ofs(acc_addr[6:0]),
        .wr_data(wr_word), .frame_pos(frame_pos_in), .rd_data(reg_rd), .ctrl(ctrl)
    );

    tsw_mem_bank #(.WIDTH(HDATA_W), .DEPTH(STREAMS * CHANS)) u_conn_mem (
        .clk(clk), .we(cm_we), .w_idx(mem_idx), .w_data(wr_word),
        .r_idx(mem_idx), .r_data(cm_rd)
    );

    tsw_mem_bank #(.WIDTH(DM_W), .DEPTH(STREAMS * CHANS)) u_data_mem (
        .clk(clk), .we(sw_dm_we), .w_idx(sw_dm_idx), .w_data(sw_dm_data),
        .r_idx(mem_idx), .r_data(dm_rd)
    );

    // Select read data by region; data memory is zero-extended.
    always_comb begin
        case (region)
            RGN_CONN: rd_mux = cm_rd;
            RGN_DATA: rd_mux = {{(HDATA_W-DM_W){1'b0}}, dm_rd};
            default:  rd_mux = reg_rd;
        endcase
    end

    // Capture read data at the access edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (access && rd_wr_n)
            rdata_q <= rd_mux;
    end

    // Drive the bus outputs and the acknowledge.
    always_comb begin
        d_lo_out = rdata_q[7:0];
        d_hi_out = rdata_q[15:8];
        d_oe     = ack && rd_wr_n && !cs_n;
        dta_n    = !ack;
    end
endmodule

// File: rtl/tsw_host_port_chk.sv
// Module: checker for the host-port handshake and the address hold, bound to the top.
module tsw_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_shared,
    input logic       addr_stb,
    input logic       cs_n,
    input logic       ds_n,
    input logic       rd_wr_n,
    input logic       dta_n,
    input logic       d_oe,
    input logic [7:0] acc_addr
);
    // R9
    ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dta_n) |-> $past(!cs_n && !ds_n));

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dta_n && (ds_n || cs_n)) |=> dta_n);

    // R10
    ack_idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dta_n);

    // R11
    drive_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> (!dta_n && rd_wr_n && !cs_n));

    // R1
    shared_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_shared && $past(bus_shared) && $past(rst_n) && !$past(addr_stb))
            |-> $stable(acc_addr));
endmodule

bind tsw_host_port tsw_host_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_shared(bus_shared), .addr_stb(addr_stb),
    .cs_n(cs_n), .ds_n(ds_n), .rd_wr_n(rd_wr_n), .dta_n(dta_n), .d_oe(d_oe),
    .acc_addr(acc_addr)
);

// File: tb/tsw_host_port_bench.sv
module tsw_host_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_shared = 1'b0, addr_stb = 1'b0, cs_n = 1'b1, ds_n = 1'b1, rd_wr_n = 1'b1;
    logic [7:0]  addr_in = '0, d_lo_in = '0, d_hi_in = '0;
    logic [7:0]  d_lo_out, d_hi_out;
    logic        d_oe, dta_n;
    logic [15:0] frame_pos_in = 16'h5A5A;
    logic        sw_dm_we = 1'b0;
    logic [8:0]  sw_dm_idx = '0;
    logic [7:0]  sw_dm_data = '0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tsw_host_port u_tsw_host_port (
        .clk(clk), .rst_n(rst_n), .bus_shared(bus_shared), .addr_stb(addr_stb),
        .addr_in(addr_in), .cs_n(cs_n), .ds_n(ds_n), .rd_wr_n(rd_wr_n),
        .d_lo_in(d_lo_in), .d_hi_in(d_hi_in), .d_lo_out(d_lo_out), .d_hi_out(d_hi_out),
        .d_oe(d_oe), .dta_n(dta_n), .frame_pos_in(frame_pos_in),
        .sw_dm_we(sw_dm_we), .sw_dm_idx(sw_dm_idx), .sw_dm_data(sw_dm_data)
    );

    typedef struct packed {
        logic        shared;
        logic        rd;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [15:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'h00, 16'h0000, 16'h0000, 4'd3},  // R3 ctrl: stream 0, conn mem
        '{1'b0, 1'b0, 8'h01, 16'h1234, 16'h0000, 4'd3},  // R2 write imode
        '{1'b1, 1'b1, 8'h01, 16'h0000, 16'h1234, 4'd1},  // R1 shared-mode read
        '{1'b0, 1'b0, 8'h03, 16'hBEEF, 16'h0000, 4'd3},
        '{1'b1, 1'b1, 8'h03, 16'h0000, 16'hBEEF, 4'd3},  // R3 frame offset
        '{1'b0, 1'b1, 8'h02, 16'h0000, 16'h5A5A, 4'd4},  // R4 frame word
        '{1'b1, 1'b0, 8'h02, 16'hFFFF, 16'h0000, 4'd4},
        '{1'b0, 1'b1, 8'h02, 16'h0000, 16'h5A5A, 4'd4},  // R4 write ignored
        '{1'b0, 1'b0, 8'h05, 16'h7777, 16'h0000, 4'd5},
        '{1'b0, 1'b1, 8'h05, 16'h0000, 16'h0000, 4'd5},  // R5 reads zero
        '{1'b0, 1'b1, 8'h01, 16'h0000, 16'h1234, 4'd5},  // R5 imode untouched
        '{1'b0, 1'b0, 8'h85, 16'hA1A1, 16'h0000, 4'd6},
        '{1'b1, 1'b1, 8'h85, 16'h0000, 16'hA1A1, 4'd6},  // R6 conn mem
        '{1'b0, 1'b0, 8'h00, 16'h0002, 16'h0000, 4'd8},  // stream 2
        '{1'b0, 1'b1, 8'h85, 16'h0000, 16'h0000, 4'd8},  // R8 fresh stream
        '{1'b0, 1'b0, 8'h85, 16'h0C0C, 16'h0000, 4'd8},
        '{1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        '{1'b0, 1'b1, 8'h85, 16'h0000, 16'hA1A1, 4'd8},  // R8 stream 0 kept
        '{1'b0, 1'b0, 8'h00, 16'h0082, 16'h0000, 4'd7},  // data mem, stream 2
        '{1'b1, 1'b1, 8'h00, 16'h0000, 16'h0082, 4'd3},
        '{1'b0, 1'b1, 8'h85, 16'h0000, 16'h003C, 4'd7},  // R7 data mem read
        '{1'b1, 1'b0, 8'h85, 16'hFFFF, 16'h0000, 4'd7},
        '{1'b0, 1'b1, 8'h85, 16'h0000, 16'h003C, 4'd7},  // R7 write blocked
        '{1'b0, 1'b1, 8'h85, 16'h0000, 16'h003C, 4'd7}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One bus transfer; checks the handshake (R9, R11) and returns read data.
    task automatic bus_xfer(input logic sh, input logic rd, input logic [7:0] a,
                            input logic [15:0] wd, output logic [15:0] rv);
        @(negedge clk);
        bus_shared = sh;
        if (sh) begin
            addr_stb = 1'b1; d_lo_in = a; addr_in = 8'h00;
            @(negedge clk);
            addr_stb = 1'b0;
        end else begin
            addr_in = a;
        end
        d_lo_in = wd[7:0]; d_hi_in = wd[15:8];
        rd_wr_n = rd; cs_n = 1'b0; ds_n = 1'b0;
        @(negedge clk);
        chk("R9", {15'd0, dta_n}, 16'd0);
        chk("R11", {15'd0, d_oe}, {15'd0, rd});
        rv = {d_hi_out, d_lo_out};
        @(negedge clk);
        chk("R9", {15'd0, dta_n}, 16'd0);
        ds_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        chk("R9", {15'd0, dta_n}, 16'd1);
        chk("R11", {15'd0, d_oe}, 16'd0);
    endtask

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", {15'd0, dta_n}, 16'd1);
        chk("R10", {15'd0, d_oe}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", {15'd0, dta_n}, 16'd1);
        bus_xfer(1'b0, 1'b1, 8'h00, 16'h0, rv);
        chk("R10", rv, 16'h0000);
        bus_xfer(1'b1, 1'b1, 8'h03, 16'h0, rv);
        chk("R10", rv, 16'h0000);
        // preload data memory, stream 2 channel 5
        @(negedge clk);
        sw_dm_we = 1'b1; sw_dm_idx = {2'd2, 7'd5}; sw_dm_data = 8'h3C;
        @(negedge clk);
        sw_dm_we = 1'b0;
        for (int i = 0; i < NV; i++) begin
            bus_xfer(VEC[i].shared, VEC[i].rd, VEC[i].addr, VEC[i].wdata, rv);
            if (VEC[i].rd)
                chk($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].expv);
        end
        // R9 long strobe: acknowledge held, released one clock after removal
        @(negedge clk);
        bus_shared = 1'b0; addr_in = 8'h01; rd_wr_n = 1'b1; cs_n = 1'b0; ds_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk("R9", {15'd0, dta_n}, 16'd0);
        end
        chk("R11", {d_hi_out, d_lo_out}, 16'h1234);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R9", {15'd0, dta_n}, 16'd1);
        ds_n = 1'b1;
        // R1 address held: strobe stays low while data bus changes
        bus_xfer(1'b1, 1'b0, 8'h01, 16'h0081, rv);
        bus_xfer(1'b0, 1'b1, 8'h01, 16'h0, rv);
        chk("R1", rv, 16'h0081);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule